// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is the serial engine of an SPI master. A host loads a transmit byte, picks the clock polarity, the clock phase, the bit order and a clock divider, and pulses a start strobe. The block then runs one 8-bit full-duplex exchange. It shifts the transmit byte out on MOSI and, on the same SCLK edges, collects a byte from MISO. It flags the end of the exchange with a single-cycle interrupt pulse. The receive byte is always captured, whether or not the slave had anything meaningful to send.

Slave select is not part of the block. The host drives it low through an ordinary output pin before the start strobe and releases it after the interrupt. The block has no acknowledgement, no flow control and no error reporting. Each new exchange simply replaces the previous receive byte.

The controller has five states. ST_IDLE parks SCLK at the selected idle level. ST_SETUP holds SCLK idle for one half-period after a start. ST_LEAD covers the half-period after each leading edge. ST_TRAIL covers the half-period after each trailing edge, except the last. ST_DONE lasts one cycle and carries the interrupt. The transitions are:
- start: ST_IDLE to ST_SETUP, and ST_DONE to ST_SETUP.
- lead_edge: ST_SETUP to ST_LEAD, and ST_TRAIL to ST_LEAD.
- trail_edge: ST_LEAD to ST_TRAIL.
- last_edge: ST_LEAD to ST_DONE.
- retire: ST_DONE to ST_IDLE when no start is present.

Top module: `spim_core`

## Requirements
- R1: After reset, busy_o, done_irq_o, mosi_o and rx_byte_o are all 0.
- R2: While no exchange runs, sclk_o equals the value of cfg_cpol from the previous cycle (1 = idle high, 0 = idle low), and it toggles only while busy_o is 1.
- R3: Each exchange produces exactly 16 SCLK edges. The slave receives the transmit byte and rx_byte_o ends up holding the byte the slave sent, in all four combinations of cfg_cpol and cfg_cpha.
- R4: With cfg_cpha = 0, the first MOSI bit is present before the first SCLK edge, both sides sample on leading edges and data changes on trailing edges. With cfg_cpha = 1, data changes on leading edges and both sides sample on trailing edges.
- R5: cfg_lsb_first = 1 sends and receives bit 0 first; cfg_lsb_first = 0 sends and receives bit 7 first. The setting applies to MOSI and MISO alike.
- R6: Each SCLK half-period lasts max(cfg_half_div, 2) system clock cycles, so a value of 0 or 1 behaves like 2.
- R7: busy_o rises only in the cycle after an accepted start_i and stays high for exactly 16 half-periods.
- R8: done_irq_o is a single-cycle pulse in the cycle busy_o falls. rx_byte_o is valid in that cycle and holds its value until the next exchange begins.
- R9: A start_i while busy_o is 1 is ignored. The running exchange keeps its data and length, and only one done pulse follows.
- R10: A start_i in the cycle of the done pulse is accepted. busy_o is high in the next cycle, and the new exchange overwrites rx_byte_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first; 0: bit 7 first |
| cfg_half_div | input | DIV_W | SCLK half-period in system clocks (minimum 2) |
| start_i | input | 1 | Start strobe |
| tx_byte_i | input | WIDTH | Byte to transmit, taken when a start is accepted |
| rx_byte_o | output | WIDTH | Byte received in the latest exchange |
| busy_o | output | 1 | An exchange is in progress |
| done_irq_o | output | 1 | One-cycle completion interrupt |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |

## Verification
The completion pulse and the acceptance of a new start can happen in the same cycle. To provoke this, the bench raises start_i in the exact cycle it sees done_irq_o. It then checks that busy_o is high in the following cycle, that the pulse has ended, and that the second exchange replaces rx_byte_o with the new slave byte. A second collision is a start strobe arriving in the middle of an exchange. The bench judges that case by confirming that the busy length, the data seen by the slave model and the number of done pulses are unchanged.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_TRAIL,
        ST_DONE
    } spim_state_e;

    localparam int unsigned SPIM_MIN_HALF = 2;

endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    import spim_pkg::*;

    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(SPIM_MIN_HALF);

    logic [DIV_W-1:0] half_eff;
    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;

    // Clamp the divider so every half-period spans at least two clocks
    assign half_eff = (half_i < MIN_HALF) ? MIN_HALF : half_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= MIN_HALF;
            cnt_q  <= '0;
        end else if (load_i) begin
            half_q <= half_eff;
            cnt_q  <= half_eff - 1'b1;
        end else if (run_i) begin
            if (cnt_q == '0) begin
                cnt_q <= half_q - 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             lsb_first_i,
    input  logic [WIDTH-1:0] tx_i,
    input  logic             shift_out_i,
    input  logic             sample_in_i,
    input  logic             miso_i,
    output logic             mosi_o,
    output logic [WIDTH-1:0] rx_o
);
    logic [WIDTH-1:0] tx_sr;
    logic [WIDTH-1:0] rx_sr;
    logic [WIDTH-1:0] tx_rev;
    logic [WIDTH-1:0] rx_rev;
    logic             lsb_q;

    // Bit-reversed views let one left-shifting datapath serve both orders
    for (genvar g = 0; g < WIDTH; g++) begin : g_rev
        assign tx_rev[g] = tx_i[WIDTH-1-g];
        assign rx_rev[g] = rx_sr[WIDTH-1-g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            lsb_q <= 1'b0;
        end else if (load_i) begin
            tx_sr <= lsb_first_i ? tx_rev : tx_i;
            lsb_q <= lsb_first_i;
        end else if (shift_out_i) begin
            tx_sr <= {tx_sr[WIDTH-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sample_in_i) begin
            rx_sr <= {rx_sr[WIDTH-2:0], miso_i};
        end
    end

    assign mosi_o = tx_sr[WIDTH-1];
    assign rx_o   = lsb_q ? rx_rev : rx_sr;

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
    parameter int unsigned WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    input  logic cfg_cpol,
    input  logic cfg_cpha,
    output logic load_o,
    output logic run_o,
    output logic shift_out_o,
    output logic sample_in_o,
    output logic sclk_o,
    output logic busy_o,
    output logic done_o
);
    import spim_pkg::*;

    localparam int unsigned BIT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WIDTH - 1);

    spim_state_e state_q;
    spim_state_e state_d;
    logic [BIT_W-1:0] bit_q;
    logic cpha_q;
    logic sclk_q;
    logic accept;
    logic lead_edge;
    logic trail_edge;
    logic running;

    assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SETUP;
            ST_SETUP: if (tick_i) state_d = ST_LEAD;
            ST_LEAD:  if (tick_i) state_d = (bit_q == LAST_BIT) ? ST_DONE : ST_TRAIL;
            ST_TRAIL: if (tick_i) state_d = ST_LEAD;
            ST_DONE:  state_d = accept ? ST_SETUP : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        running     = (state_q == ST_SETUP) || (state_q == ST_LEAD) || (state_q == ST_TRAIL);
        lead_edge   = tick_i && ((state_q == ST_SETUP) || (state_q == ST_TRAIL));
        trail_edge  = tick_i && (state_q == ST_LEAD);
        load_o      = accept;
        run_o       = running;
        busy_o      = running;
        done_o      = (state_q == ST_DONE);
        sample_in_o = cpha_q ? trail_edge : lead_edge;
        shift_out_o = cpha_q ? (lead_edge && (state_q == ST_TRAIL))
                             : (trail_edge && (bit_q != LAST_BIT));
        sclk_o      = sclk_q;
    end

    // Bit counter, latched phase and serial clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            cpha_q <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            if (accept) begin
                bit_q  <= '0;
                cpha_q <= cfg_cpha;
            end else if (trail_edge) begin
                bit_q <= bit_q + 1'b1;
            end
            if (!running) begin
                sclk_q <= cfg_cpol;
            end else if (tick_i) begin
                sclk_q <= ~sclk_q;
            end
        end
    end

endmodule

// File: rtl/spim_core.sv
module spim_core #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic             start_i,
    input  logic [WIDTH-1:0] tx_byte_i,
    output logic [WIDTH-1:0] rx_byte_o,
    output logic             busy_o,
    output logic             done_irq_o,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i
);
    logic load;
    logic run;
    logic tick;
    logic shift_out;
    logic sample_in;

    spim_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .tick_i      (tick),
        .cfg_cpol    (cfg_cpol),
        .cfg_cpha    (cfg_cpha),
        .load_o      (load),
        .run_o       (run),
        .shift_out_o (shift_out),
        .sample_in_o (sample_in),
        .sclk_o      (sclk_o),
        .busy_o      (busy_o),
        .done_o      (done_irq_o)
    );

    spim_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .run_i  (run),
        .half_i (cfg_half_div),
        .tick_o (tick)
    );

    spim_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .lsb_first_i (cfg_lsb_first),
        .tx_i        (tx_byte_i),
        .shift_out_i (shift_out),
        .sample_in_i (sample_in),
        .miso_i      (miso_i),
        .mosi_o      (mosi_o),
        .rx_o        (rx_byte_o)
    );

endmodule

// File: rtl/spim_core_chk.sv
module spim_core_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             cfg_cpol,
    input logic             busy_o,
    input logic             done_irq_o,
    input logic             sclk_o,
    input logic [WIDTH-1:0] rx_byte_o
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |=> !done_irq_o);

    assert_irq_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |-> !busy_o);

    assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(busy_o)) |-> $past(start_i));

    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !busy_o && !$past(busy_o)) |-> (sclk_o == $past(cfg_cpol)));

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !busy_o && !$past(busy_o)) |-> $stable(rx_byte_o));

endmodule

bind spim_core spim_core_chk #(.WIDTH(WIDTH)) u_spim_core_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cfg_cpol   (cfg_cpol),
    .busy_o     (busy_o),
    .done_irq_o (done_irq_o),
    .sclk_o     (sclk_o),
    .rx_byte_o  (rx_byte_o)
);

// File: tb/test_spim_core.sv
module test_spim_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0;
    logic       cfg_cpha = 1'b0;
    logic       cfg_lsb_first = 1'b0;
    logic [7:0] cfg_half_div = 8'd2;
    logic       start_i = 1'b0;
    logic [7:0] tx_byte_i = 8'h00;
    logic [7:0] rx_byte_o;
    logic       busy_o;
    logic       done_irq_o;
    logic       sclk_o;
    logic       mosi_o;
    logic       miso_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spim_core i_spim_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_cpol      (cfg_cpol),
        .cfg_cpha      (cfg_cpha),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_half_div  (cfg_half_div),
        .start_i       (start_i),
        .tx_byte_i     (tx_byte_i),
        .rx_byte_o     (rx_byte_o),
        .busy_o        (busy_o),
        .done_irq_o    (done_irq_o),
        .sclk_o        (sclk_o),
        .mosi_o        (mosi_o),
        .miso_i        (miso_i)
    );

    // {cpol, cpha, lsb_first, half_div[7:0], tx[7:0], slave_tx[7:0]}
    localparam int NVEC = 8;
    localparam logic [26:0] VEC [NVEC] = '{
        {3'b000, 8'd2, 8'hA5, 8'h3C},
        {3'b010, 8'd3, 8'h96, 8'hC3},
        {3'b100, 8'd4, 8'h5A, 8'h81},
        {3'b110, 8'd2, 8'hF0, 8'h0F},
        {3'b001, 8'd0, 8'h01, 8'h80},
        {3'b011, 8'd1, 8'h80, 8'h01},
        {3'b101, 8'd5, 8'h6D, 8'hB2},
        {3'b111, 8'd3, 8'h00, 8'hFF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    bit         slv_on = 1'b0;
    int         slv_edge = 0;
    logic [7:0] slv_tx = 8'h00;
    logic [7:0] slv_rx = 8'h00;

    function automatic logic pick(input logic [7:0] b, input int k, input logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    always @(sclk_o) begin
        if (slv_on) begin
            slv_edge++;
            begin
                bit lead;
                bit samp;
                int idx;
                lead = (slv_edge % 2) == 1;
                samp = cfg_cpha ? !lead : lead;
                idx = (slv_edge - 1) / 2;
                if (samp && idx < 8) begin
                    if (cfg_lsb_first) slv_rx[idx] = mosi_o;
                    else               slv_rx[7-idx] = mosi_o;
                end
                if (!samp) begin
                    if (cfg_cpha && idx < 8)            miso_i = pick(slv_tx, idx, cfg_lsb_first);
                    if (!cfg_cpha && (slv_edge / 2) < 8) miso_i = pick(slv_tx, slv_edge / 2, cfg_lsb_first);
                end
            end
        end
    end

    // ---------------- monitor ----------------
    bit   mon_on = 1'b0;
    logic prev_sclk = 1'b0;
    int   busy_cnt, irq_cnt, edge_cnt, gap, gap_min, gap_max;

    always @(negedge clk) begin
        if (mon_on) begin
            busy_cnt += int'(busy_o);
            irq_cnt  += int'(done_irq_o);
            if (sclk_o != prev_sclk) begin
                if (edge_cnt > 0) begin
                    if (gap < gap_min) gap_min = gap;
                    if (gap > gap_max) gap_max = gap;
                end
                gap = 1;
                edge_cnt++;
            end else begin
                gap++;
            end
            prev_sclk = sclk_o;
        end
    end

    task automatic arm(input logic [7:0] stx, input logic [7:0] tx);
        slv_tx   = stx;
        slv_rx   = 8'h00;
        slv_edge = 0;
        miso_i   = pick(stx, 0, cfg_lsb_first);
        busy_cnt = 0; irq_cnt = 0; edge_cnt = 0; gap = 0;
        gap_min  = 1 << 30; gap_max = 0;
        prev_sclk = sclk_o;
        slv_on   = 1'b1;
        mon_on   = 1'b1;
        tx_byte_i = tx;
        start_i   = 1'b1;
    endtask

    task automatic wait_irq(input logic [7:0] tx_alt, input int inject);
        int n = 0;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_irq_o && n < 10000) begin
            @(negedge clk);
            n++;
            start_i = 1'b0;
            if (inject > 0 && n == inject) begin
                start_i   = 1'b1;
                tx_byte_i = tx_alt;
            end
        end
    endtask

    task automatic finish_checks(input logic [7:0] tx, input logic [7:0] stx, input int h,
                                 input logic cpol, input string tag);
        chk(busy_o == 1'b0, {tag, " R8 busy low with irq"}, busy_o, 0);
        chk(rx_byte_o == stx, {tag, " R3 R5 rx byte"}, rx_byte_o, stx);
        @(negedge clk);
        chk(done_irq_o == 1'b0, {tag, " R8 irq one cycle"}, done_irq_o, 0);
        chk(sclk_o == cpol, {tag, " R2 sclk back to idle"}, sclk_o, cpol);
        chk(slv_rx == tx, {tag, " R3 R4 R5 slave received"}, slv_rx, tx);
        chk(edge_cnt == 16, {tag, " R3 edge count"}, edge_cnt, 16);
        chk(busy_cnt == 16 * h, {tag, " R7 busy length"}, busy_cnt, 16 * h);
        chk(gap_min == h && gap_max == h, {tag, " R6 half period"}, gap_max, h);
        chk(irq_cnt == 1, {tag, " R8 R9 single irq"}, irq_cnt, 1);
        mon_on = 1'b0;
        slv_on = 1'b0;
    endtask

    task automatic run_vec(input logic [26:0] v, input int inject, input string tag);
        logic [7:0] tx, stx;
        int h;
        @(negedge clk);
        {cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_half_div, tx, stx} = v;
        h = (cfg_half_div < 2) ? 2 : int'(cfg_half_div);
        repeat (3) @(negedge clk);
        chk(sclk_o == cfg_cpol, {tag, " R2 idle level"}, sclk_o, cfg_cpol);
        arm(stx, tx);
        wait_irq(~tx, inject);
        finish_checks(tx, stx, h, cfg_cpol, tag);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(busy_o == 0, "R1 busy", busy_o, 0);
        chk(done_irq_o == 0, "R1 irq", done_irq_o, 0);
        chk(mosi_o == 0, "R1 mosi", mosi_o, 0);
        chk(rx_byte_o == 0, "R1 rx", rx_byte_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i], 0, $sformatf("vec%0d", i));

        // R9: start in the middle of an exchange is ignored
        run_vec({3'b010, 8'd3, 8'h3A, 8'h5C}, 20, "R9 mid start");
        run_vec({3'b101, 8'd2, 8'hC4, 8'h29}, 31, "R9 late start");

        // R10: start coinciding with the done pulse
        @(negedge clk);
        cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_half_div = 8'd2;
        repeat (3) @(negedge clk);
        arm(8'h77, 8'h1E);
        wait_irq(8'h00, 0);
        chk(rx_byte_o == 8'h77, "R10 first rx", rx_byte_o, 8'h77);
        chk(slv_rx == 8'h1E, "R10 first slave rx", slv_rx, 8'h1E);
        arm(8'hE1, 8'hB4);
        @(negedge clk);
        chk(busy_o == 1'b1, "R10 busy after back-to-back start", busy_o, 1);
        chk(done_irq_o == 1'b0, "R10 irq ended", done_irq_o, 0);
        start_i = 1'b0;
        wait_irq(8'h00, 0);
        chk(rx_byte_o == 8'hE1, "R10 rx overwritten", rx_byte_o, 8'hE1);
        @(negedge clk);
        chk(slv_rx == 8'hB4, "R10 second slave rx", slv_rx, 8'hB4);
        chk(busy_cnt == 32, "R10 R7 second busy length", busy_cnt, 32);
        mon_on = 1'b0;
        slv_on = 1'b0;

        // R8: rx held while idle and config changes
        cfg_lsb_first = 1'b1;
        repeat (4) @(negedge clk);
        chk(rx_byte_o == 8'hE1, "R8 rx held", rx_byte_o, 8'hE1);
        chk(sclk_o == 1'b1, "R2 idle high held", sclk_o, 1);
        cfg_cpol = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk_o == 1'b0, "R2 idle follows polarity", sclk_o, 0);

        summary();
    end

endmodule